// File: doc/BRIEF.md
# Transmit Signaling Bit Conditioner

This block prepares the four ABCD signaling bits of each channel before a later stage inserts them into the outgoing payload. Each cycle the upstream logic may offer one channel's signaling nibble, along with the channel index, the frame number inside the current multiframe and a multiframe-start flag. The block returns the conditioned nibble for that channel one clock later.

Three kinds of conditioning apply. Trunk conditioning replaces the signaling with a programmable four-bit code, either for all channels at once or only for channels whose own enable bit is set. Snapshot mode keeps the nibble seen in a multiframe's first frame and repeats it for the rest of that multiframe. A mode input for the one framing format that cannot use snapshots turns snapshot mode off. A width selector chooses between full four-bit signaling and two-bit signaling, where only A and B carry meaning.

Top module: `tx_sig_cond`

## Requirements
- R1: An input with `in_valid`=1 and `in_chan` < NUM_CH produces `out_valid`=1 on the next clock edge, with `out_chan` equal to that index. In any other cycle, and right after reset, `out_valid` is 0.
- R2: When `global_trunk_en`=1, every channel's output is `trunk_code`, whatever its per-channel enable.
- R3: When `global_trunk_en`=0, only a channel `c` with `chan_trunk_en[c]`=1 outputs `trunk_code`. Every other channel keeps its own signaling.
- R4: Trunk conditioning is applied after snapshot selection. A conditioned channel outputs `trunk_code` in snapshot mode as well.
- R5: Bit 3 is A and bit 0 is D. With `two_bit_mode`=1 the output is {bit3, bit2, 0, 0}. With `two_bit_mode`=0 all four bits pass.
- R6: With snapshot active, a capture frame (`in_frame`=0 or `in_mf_start`=1) outputs the live nibble and stores it for that channel. Any other frame outputs the stored nibble of that channel.
- R7: `dm_mode`=1 disables snapshot mode. Live signaling is output in every frame, and nothing is stored.
- R8: In snapshot mode, a channel that has had no capture since reset outputs its live nibble.
- R9: An input with `in_chan` >= NUM_CH is dropped. It produces no output and changes no stored snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input item present |
| in_chan | input | CH_W | Channel index |
| in_frame | input | FRM_W | Frame number within the multiframe |
| in_mf_start | input | 1 | First frame of a multiframe |
| in_sig | input | 4 | Live ABCD nibble (bit 3 = A) |
| snap_en | input | 1 | Snapshot mode request |
| dm_mode | input | 1 | Framing format without snapshot support |
| two_bit_mode | input | 1 | Only A and B are valid |
| global_trunk_en | input | 1 | Condition all channels |
| chan_trunk_en | input | NUM_CH | Per-channel conditioning enables |
| trunk_code | input | 4 | Conditioning code |
| out_valid | output | 1 | Output item present |
| out_chan | output | CH_W | Channel of the output item |
| out_sig | output | 4 | Conditioned nibble |

## Verification
Snapshot replay and trunk replacement can act on the same item in the same cycle. A snapshot-mode channel is captured with one nibble, and later frames present different live bits. The bench then turns on that channel's trunk enable, alone and together with two-bit mode. The scoreboard requires the trunk code, masked when two-bit mode is on, rather than either the stored or the live nibble. It also checks that channels without the enable still replay their stored nibble in the same sequence.

// File: rtl/tx_sig_pkg.sv
package tx_sig_pkg;
  localparam int SIG_W     = 4;             // ABCD
  localparam int KEEP2_LSB = SIG_W - 2;     // first bit kept in two-bit mode
  typedef logic [SIG_W-1:0] sig_t;
endpackage

// File: rtl/tx_sig_snap_store.sv
// Per-channel snapshot storage: one nibble per channel plus a loaded flag.
module tx_sig_snap_store
  import tx_sig_pkg::*;
#(
  parameter int NUM_CH = 24,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [CH_W-1:0] wr_chan,
  input  sig_t            wr_sig,
  input  logic [CH_W-1:0] rd_chan,
  output sig_t            rd_sig,
  output logic            rd_loaded
);
  sig_t              mem [NUM_CH];
  logic [NUM_CH-1:0] loaded_q;

  // data array: no reset, so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_chan] <= wr_sig;
  end

  always_ff @(posedge clk) begin
    if (rst)        loaded_q <= '0;
    else if (wr_en) loaded_q[wr_chan] <= 1'b1;
  end

  assign rd_sig    = mem[rd_chan];
  assign rd_loaded = loaded_q[rd_chan];
endmodule

// File: rtl/tx_sig_select.sv
// Chooses between the live nibble and the stored snapshot.
module tx_sig_select
  import tx_sig_pkg::*;
(
  input  logic snap_active,
  input  logic capture,
  input  logic loaded,
  input  sig_t live_sig,
  input  sig_t stored_sig,
  output sig_t chosen_sig
);
  always_comb begin
    if (snap_active && !capture && loaded) chosen_sig = stored_sig;
    else                                   chosen_sig = live_sig;
  end
endmodule

// File: rtl/tx_sig_trunk_mask.sv
// Trunk replacement followed by the two-bit width mask.
module tx_sig_trunk_mask
  import tx_sig_pkg::*;
(
  input  logic trunk_hit,
  input  sig_t trunk_code,
  input  logic two_bit_mode,
  input  sig_t chosen_sig,
  output sig_t cond_sig
);
  sig_t pre_sig;
  assign pre_sig = trunk_hit ? trunk_code : chosen_sig;

  for (genvar b = 0; b < SIG_W; b++) begin : g_bit
    if (b < KEEP2_LSB) begin : g_low
      assign cond_sig[b] = two_bit_mode ? 1'b0 : pre_sig[b];
    end else begin : g_high
      assign cond_sig[b] = pre_sig[b];
    end
  end
endmodule

// File: rtl/tx_sig_cond.sv
// Transmit signaling conditioner top: one registered stage.
module tx_sig_cond
  import tx_sig_pkg::*;
#(
  parameter int NUM_CH = 24,
  parameter int FRM_W  = 5,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [CH_W-1:0]   in_chan,
  input  logic [FRM_W-1:0]  in_frame,
  input  logic              in_mf_start,
  input  logic [3:0]        in_sig,
  input  logic              snap_en,
  input  logic              dm_mode,
  input  logic              two_bit_mode,
  input  logic              global_trunk_en,
  input  logic [NUM_CH-1:0] chan_trunk_en,
  input  logic [3:0]        trunk_code,
  output logic              out_valid,
  output logic [CH_W-1:0]   out_chan,
  output logic [3:0]        out_sig
);
  localparam logic [CH_W:0] CH_LIMIT = (CH_W+1)'(NUM_CH);

  logic            in_ok, accept, snap_active, capture, wr_en, trunk_hit;
  logic            loaded;
  logic [CH_W-1:0] safe_chan;
  sig_t            stored_sig, chosen_sig, cond_sig;

  assign in_ok       = ({1'b0, in_chan} < CH_LIMIT);
  assign accept      = in_valid && in_ok;
  assign safe_chan   = in_ok ? in_chan : '0;
  assign snap_active = snap_en && !dm_mode;
  assign capture     = (in_frame == '0) || in_mf_start;
  assign wr_en       = accept && snap_active && capture;
  assign trunk_hit   = global_trunk_en || chan_trunk_en[safe_chan];

  tx_sig_snap_store #(.NUM_CH(NUM_CH)) u_store (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_chan   (safe_chan),
    .wr_sig    (in_sig),
    .rd_chan   (safe_chan),
    .rd_sig    (stored_sig),
    .rd_loaded (loaded)
  );

  tx_sig_select u_select (
    .snap_active (snap_active),
    .capture     (capture),
    .loaded      (loaded),
    .live_sig    (in_sig),
    .stored_sig  (stored_sig),
    .chosen_sig  (chosen_sig)
  );

  tx_sig_trunk_mask u_trunk (
    .trunk_hit    (trunk_hit),
    .trunk_code   (trunk_code),
    .two_bit_mode (two_bit_mode),
    .chosen_sig   (chosen_sig),
    .cond_sig     (cond_sig)
  );

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= accept;
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      out_chan <= in_chan;
      out_sig  <= cond_sig;
    end
  end
endmodule

// File: rtl/tx_sig_cond_chk.sv
module tx_sig_cond_chk #(
  parameter int NUM_CH = 24,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [CH_W-1:0]   in_chan,
  input logic [3:0]        in_sig,
  input logic              dm_mode,
  input logic              two_bit_mode,
  input logic              global_trunk_en,
  input logic [NUM_CH-1:0] chan_trunk_en,
  input logic [3:0]        trunk_code,
  input logic              out_valid,
  input logic [CH_W-1:0]   out_chan,
  input logic [3:0]        out_sig
);
  logic chk_ok;
  assign chk_ok = ({1'b0, in_chan} < (CH_W+1)'(NUM_CH));

  a_r1_valid_next: assert property (@(posedge clk) disable iff (rst)
    (in_valid && chk_ok) |=> (out_valid && out_chan == $past(in_chan)));

  a_r9_drop: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && chk_ok) |=> !out_valid);

  a_r2_global_code: assert property (@(posedge clk) disable iff (rst)
    (in_valid && chk_ok && global_trunk_en && !two_bit_mode)
      |=> out_sig == $past(trunk_code));

  a_r5_low_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && chk_ok && two_bit_mode) |=> out_sig[1:0] == 2'b00);

  a_r7_dm_live: assert property (@(posedge clk) disable iff (rst)
    (in_valid && chk_ok && dm_mode && !global_trunk_en &&
     !chan_trunk_en[in_chan] && !two_bit_mode) |=> out_sig == $past(in_sig));
endmodule

bind tx_sig_cond tx_sig_cond_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk             (clk),
  .rst             (rst),
  .in_valid        (in_valid),
  .in_chan         (in_chan),
  .in_sig          (in_sig),
  .dm_mode         (dm_mode),
  .two_bit_mode    (two_bit_mode),
  .global_trunk_en (global_trunk_en),
  .chan_trunk_en   (chan_trunk_en),
  .trunk_code      (trunk_code),
  .out_valid       (out_valid),
  .out_chan        (out_chan),
  .out_sig         (out_sig)
);

// File: tb/tx_sig_cond_bench.sv
module tx_sig_cond_bench;
  localparam int NUM_CH = 24;
  localparam int FRM_W  = 5;
  localparam int CH_W   = 5;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic [CH_W-1:0]   in_chan = '0;
  logic [FRM_W-1:0]  in_frame = '0;
  logic              in_mf_start = 1'b0;
  logic [3:0]        in_sig = '0;
  logic              snap_en = 1'b0, dm_mode = 1'b0, two_bit_mode = 1'b0;
  logic              global_trunk_en = 1'b0;
  logic [NUM_CH-1:0] chan_trunk_en = '0;
  logic [3:0]        trunk_code = '0;
  logic              out_valid;
  logic [CH_W-1:0]   out_chan;
  logic [3:0]        out_sig;

  int checks = 0, failures = 0;

  typedef struct { logic [CH_W-1:0] chan; logic [3:0] sig; string tag; } exp_t;
  exp_t exp_q[$];
  logic [3:0] m_snap [NUM_CH];
  logic [NUM_CH-1:0] m_loaded = '0;

  always #4 clk = ~clk;  // 125 MHz

  tx_sig_cond #(.NUM_CH(NUM_CH), .FRM_W(FRM_W)) u_tx_sig_cond (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_chan(in_chan),
    .in_frame(in_frame), .in_mf_start(in_mf_start), .in_sig(in_sig),
    .snap_en(snap_en), .dm_mode(dm_mode), .two_bit_mode(two_bit_mode),
    .global_trunk_en(global_trunk_en), .chan_trunk_en(chan_trunk_en),
    .trunk_code(trunk_code), .out_valid(out_valid), .out_chan(out_chan),
    .out_sig(out_sig)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver: one item per cycle, expected value computed from the requirements
  task automatic send(input int ch, input int frm, input bit mf,
                      input logic [3:0] sig, input string tag);
    exp_t e;
    logic [3:0] x;
    bit cap, act;
    @(negedge clk);
    in_valid = 1'b1; in_chan = CH_W'(ch); in_frame = FRM_W'(frm);
    in_mf_start = mf; in_sig = sig;
    cap = (frm == 0) || mf;
    act = snap_en && !dm_mode;
    x = sig;
    if (act && !cap && m_loaded[ch]) x = m_snap[ch];
    if (act && cap) begin m_snap[ch] = sig; m_loaded[ch] = 1'b1; end
    if (global_trunk_en || chan_trunk_en[ch]) x = trunk_code;
    if (two_bit_mode) x[1:0] = 2'b00;
    e.chan = CH_W'(ch); e.sig = x; e.tag = tag;
    exp_q.push_back(e);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R1/R9 unexpected out_valid", int'(out_chan), -1);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(out_chan == e.chan, {e.tag, " chan"}, int'(out_chan), int'(e.chan));
        check(out_sig == e.sig, {e.tag, " sig"}, int'(out_sig), int'(e.sig));
      end
    end
  end

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    join_none

    repeat (4) @(posedge clk);
    #2 check(out_valid == 1'b0, "R1 reset out_valid", int'(out_valid), 0);
    @(negedge clk); rst = 1'b0;

    // R8: snapshot on but nothing captured yet -> live
    snap_en = 1'b1;
    send(3, 4, 0, 4'hA, "R8 unloaded live");
    send(7, 9, 0, 4'h5, "R8 unloaded live");
    snap_en = 1'b0;

    // R1 plain pass-through, several patterns
    for (int c = 0; c < NUM_CH; c += 5) send(c, c, 0, 4'(c + 1), "R1 pass");
    send(23, 1, 0, 4'hF, "R1 last chan");

    // R2 global trunk, overrides per-channel off
    trunk_code = 4'h9; global_trunk_en = 1'b1;
    send(0, 1, 0, 4'h3, "R2 global");
    send(12, 2, 0, 4'h6, "R2 global");
    global_trunk_en = 1'b0;

    // R3 per-channel trunk
    chan_trunk_en[5] = 1'b1; trunk_code = 4'hC;
    send(5, 3, 0, 4'h1, "R3 chan on");
    send(6, 3, 0, 4'h2, "R3 chan off");
    chan_trunk_en = '0;

    // R5 two-bit mask
    two_bit_mode = 1'b1;
    send(2, 1, 0, 4'hF, "R5 mask");
    send(4, 1, 0, 4'h7, "R5 mask");
    two_bit_mode = 1'b0;

    // R6 snapshot: capture in frame 0, replay in later frames
    snap_en = 1'b1;
    send(1, 0, 0, 4'hB, "R6 capture");
    send(2, 0, 0, 4'h4, "R6 capture");
    for (int f = 1; f < 4; f++) begin
      send(1, f, 0, 4'(f), "R6 replay");
      send(2, f, 0, 4'(f + 8), "R6 replay");
    end
    // recapture at multiframe start flag with nonzero frame number
    send(1, 5, 1, 4'h3, "R6 mf_start capture");
    send(1, 6, 0, 4'hE, "R6 replay new");

    // R4 trunk after snapshot, also with two-bit mode (same-cycle overlap)
    chan_trunk_en[1] = 1'b1; trunk_code = 4'hD;
    send(1, 7, 0, 4'h0, "R4 trunk over snap");
    send(2, 7, 0, 4'h0, "R4 other chan replays");
    two_bit_mode = 1'b1;
    send(1, 8, 0, 4'h0, "R4 trunk+mask");
    two_bit_mode = 1'b0; chan_trunk_en = '0;

    // R7 dm mode: live every frame, no capture
    dm_mode = 1'b1;
    send(2, 2, 0, 4'h7, "R7 dm live");
    send(9, 0, 0, 4'h8, "R7 dm no store");
    dm_mode = 1'b0;
    send(9, 1, 0, 4'h1, "R7 nothing stored");
    send(2, 3, 0, 4'h0, "R7 old snapshot kept");
    snap_en = 1'b0;

    // R9 out-of-range channel dropped and stores nothing
    snap_en = 1'b1;
    @(negedge clk);
    in_valid = 1'b1; in_chan = 5'd30; in_frame = '0; in_sig = 4'h6;
    @(posedge clk); #1 in_valid = 1'b0;
    @(posedge clk); #2 check(out_valid == 1'b0, "R9 dropped", int'(out_valid), 0);
    send(2, 4, 0, 4'h1, "R9 store intact");
    snap_en = 1'b0;

    repeat (4) @(posedge clk);
    #2 check(exp_q.size() == 0, "R1 all outputs seen", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule